// File: doc/BRIEF.md
# Accumulator ALU Stage with Registered Flags

This block is the arithmetic and logic stage of an 8-bit accumulator processor. One operation enters with the accumulator value, the index register value, a memory operand, the current flag set and an operation code. The block computes the result byte and a new set of sign, overflow, zero and carry flags. Both are held in one output register until the consumer takes them. Flags that the chosen operation does not define are passed through from the incoming flag set. Decimal arithmetic is not supported, and there is no decimal input.

Both edges of the stage use a valid/ready handshake. A transfer happens on a rising clock edge where valid and ready are both high. The input side is ready whenever the output register is empty, or whenever it is being emptied in the same cycle. So when the consumer holds `out_ready` high, the stage accepts one operation per cycle. When `out_ready` is low and a result is waiting, `in_ready` falls and the upstream side must hold its operation. Shift and rotate codes act on the memory operand. To shift the accumulator, pass it on `in_m`. Combined read-modify-write codes return the new accumulator value. The writeback destination (A or X) is chosen outside the block.

Top module: `acc_alu_stage`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_result` and `out_flags` are all zero. Flag vectors are packed with N in bit 3, V in bit 2, Z in bit 1 and C in bit 0.
- R2: An operation is taken on a rising edge when `in_valid` and `in_ready` are both high, where `in_ready` = !`out_valid` || `out_ready`. Its result appears one cycle later with `out_valid` high. While `out_valid` is high and `out_ready` is low, the result and flags hold steady. Results leave in the order the operations were accepted.
- R3: Code 0 (add) forms s = A + M + Cin. Code 1 (subtract) forms s = A + ~M + Cin, so a set carry means no borrow. For both, C = bit 8 of s, V = bit 7 of (s^A)&(s^operand added), N and Z come from the low byte, and the result is the low byte.
- R4: Code 5 compares A and code 6 compares X against M. C = register >= M unsigned, Z = register == M, N = bit 7 of (register − M). V is kept and the result is A.
- R5: Codes 2, 3 and 4 give A AND M, A OR M and A XOR M. N and Z come from the result, and C and V are kept.
- R6: Code 7 (bit test) sets N = M[7], V = M[6] and Z = ((A AND M) == 0). C is kept and the result is A.
- R7: Codes 8 to 11 act on M: shift left, shift right, rotate left and rotate right. Each rotate goes through the carry. In all four, the bit pushed out becomes C, and V is kept. For the rotates, the old C fills the vacated end.
- R8: Code 12 gives r = A AND M with C = r[7]. Code 14 gives t = A AND M, C = t[0] and r = t >> 1. Code 13 gives r = {Cin, (A AND M)[7:1]}, C = r[6] and V = r[6] ^ r[5]. All three take N and Z from r.
- R9: Code 15 gives r = (A AND X) − M modulo 256, with C = (A AND X) >= M. N and Z come from r, and V is kept.
- R10: Codes 16 to 19 are the combined operations:
  - Code 16: A OR (M << 1), with C = M[7].
  - Code 17: A AND (M rotated left through C), with C = M[7].
  - Code 18: A XOR (M >> 1), with C = M[0].
  - Code 19: A + ({Cin, M[7:1]}) + M[0], with C and V from that sum as in R3.

  In all four, N and Z come from the final accumulator value.
- R11: Codes 20 to 31 are unassigned. They return A and pass all four incoming flags through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Stage can take an operation |
| in_op | input | 5 | Operation code |
| in_a | input | 8 | Accumulator value |
| in_x | input | 8 | Index register value |
| in_m | input | 8 | Memory operand |
| in_flags | input | 4 | Current flags {N,V,Z,C} |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 8 | Result byte |
| out_flags | output | 4 | New flags {N,V,Z,C} |

## Verification
The bench aims at the following carry and overflow corners, and the wrong behaviour each one catches:
- Signed overflow at 0x7F+1, and the wrap 0xFF+1 that sets carry and zero together. A design that takes V from the raw carry, or Z from the 9-bit sum, gets these wrong.
- Equal and less-than compares, where an inverted borrow would show up as a flipped C.
- The AND-then-rotate code, whose C and V come from bits 6 and 5. Reading them from the ends of the byte would be caught here.
- The rotate-then-add code, where the bit shifted out must feed the add as its carry.

Random operations, including the unassigned codes, run under a randomly stalling consumer. A stage that lost or repeated a result under back-pressure, or clobbered a flag an operation should keep, would diverge from the queue-based model.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int FLAG_N = 3;
  localparam int FLAG_V = 2;
  localparam int FLAG_Z = 1;
  localparam int FLAG_C = 0;

  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,
    OP_SUB   = 5'd1,
    OP_AND   = 5'd2,
    OP_OR    = 5'd3,
    OP_XOR   = 5'd4,
    OP_CMPA  = 5'd5,
    OP_CMPX  = 5'd6,
    OP_TEST  = 5'd7,
    OP_SHL   = 5'd8,
    OP_SHR   = 5'd9,
    OP_ROTL  = 5'd10,
    OP_ROTR  = 5'd11,
    OP_ANDC  = 5'd12,
    OP_ANDR  = 5'd13,
    OP_ANDS  = 5'd14,
    OP_XSUB  = 5'd15,
    OP_SHLOR = 5'd16,
    OP_ROLAN = 5'd17,
    OP_SHRXR = 5'd18,
    OP_RORAD = 5'd19
  } alu_op_e;

  function automatic logic uses_adder(alu_op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_CMPA) ||
           (op == OP_CMPX) || (op == OP_XSUB) || (op == OP_RORAD);
  endfunction

endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] m,
  input  logic [3:0]    fin,
  output logic [DW-1:0] res,
  output logic [3:0]    fout
);
  localparam int SW = DW + 1;

  logic [DW-1:0] lhs, rhs;
  logic          cy_in;
  logic [SW-1:0] sum;

  // One shared adder: subtraction and compares add the inverted operand
  always_comb begin
    lhs   = a;
    rhs   = m;
    cy_in = fin[FLAG_C];
    unique case (op)
      OP_SUB:  rhs = ~m;
      OP_CMPA: begin rhs = ~m; cy_in = 1'b1; end
      OP_CMPX: begin lhs = x; rhs = ~m; cy_in = 1'b1; end
      OP_XSUB: begin lhs = a & x; rhs = ~m; cy_in = 1'b1; end
      OP_RORAD: begin rhs = {fin[FLAG_C], m[DW-1:1]}; cy_in = m[0]; end
      default: ;
    endcase
  end

  assign sum = {1'b0, lhs} + {1'b0, rhs} + {{DW{1'b0}}, cy_in};

  always_comb begin
    fout         = fin;
    fout[FLAG_C] = sum[DW];
    fout[FLAG_N] = sum[DW-1];
    fout[FLAG_Z] = (sum[DW-1:0] == '0);
    if (op == OP_ADD || op == OP_SUB || op == OP_RORAD)
      fout[FLAG_V] = (sum[DW-1] ^ lhs[DW-1]) & (sum[DW-1] ^ rhs[DW-1]);
    res = (op == OP_CMPA || op == OP_CMPX) ? a : sum[DW-1:0];
  end

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] m,
  input  logic [3:0]    fin,
  output logic [DW-1:0] res,
  output logic [3:0]    fout
);
  logic          cin;
  logic [DW-1:0] both;
  logic [DW-1:0] shl, shr, rol, ror;

  assign cin  = fin[FLAG_C];
  assign both = a & m;
  assign shl  = {m[DW-2:0], 1'b0};
  assign shr  = {1'b0, m[DW-1:1]};
  assign rol  = {m[DW-2:0], cin};
  assign ror  = {cin, m[DW-1:1]};

  always_comb begin
    res  = a;
    fout = fin;
    unique case (op)
      OP_AND:   res = both;
      OP_OR:    res = a | m;
      OP_XOR:   res = a ^ m;
      OP_SHL:   begin res = shl; fout[FLAG_C] = m[DW-1]; end
      OP_SHR:   begin res = shr; fout[FLAG_C] = m[0]; end
      OP_ROTL:  begin res = rol; fout[FLAG_C] = m[DW-1]; end
      OP_ROTR:  begin res = ror; fout[FLAG_C] = m[0]; end
      OP_ANDC:  begin res = both; fout[FLAG_C] = both[DW-1]; end
      OP_ANDS:  begin res = {1'b0, both[DW-1:1]}; fout[FLAG_C] = both[0]; end
      OP_ANDR:  begin
        res          = {cin, both[DW-1:1]};
        fout[FLAG_C] = res[DW-2];
        fout[FLAG_V] = res[DW-2] ^ res[DW-3];
      end
      OP_SHLOR: begin res = a | shl; fout[FLAG_C] = m[DW-1]; end
      OP_ROLAN: begin res = a & rol; fout[FLAG_C] = m[DW-1]; end
      OP_SHRXR: begin res = a ^ shr; fout[FLAG_C] = m[0]; end
      default: ;
    endcase
    // sign and zero follow the result for every defined code here except the test
    if (op == OP_TEST) begin
      fout[FLAG_N] = m[DW-1];
      fout[FLAG_V] = m[DW-2];
      fout[FLAG_Z] = (both == '0);
    end else if (op inside {OP_AND, OP_OR, OP_XOR, OP_SHL, OP_SHR, OP_ROTL,
                            OP_ROTR, OP_ANDC, OP_ANDS, OP_ANDR, OP_SHLOR,
                            OP_ROLAN, OP_SHRXR}) begin
      fout[FLAG_N] = res[DW-1];
      fout[FLAG_Z] = (res == '0);
    end
  end

endmodule

// File: rtl/acc_alu_stage.sv
module acc_alu_stage
  import acc_alu_pkg::*;
#(
  parameter int DW = 8,
  parameter int OPW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [OPW-1:0] in_op,
  input  logic [DW-1:0]  in_a,
  input  logic [DW-1:0]  in_x,
  input  logic [DW-1:0]  in_m,
  input  logic [3:0]     in_flags,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [DW-1:0]  out_result,
  output logic [3:0]     out_flags
);
  alu_op_e       op;
  logic [DW-1:0] ar_res, lg_res, nxt_res;
  logic [3:0]    ar_f, lg_f, nxt_f;
  logic          take;
  alu_op_e       op_q;

  assign op = alu_op_e'(in_op);

  acc_alu_arith #(.DW(DW)) u_arith (
    .op(op), .a(in_a), .x(in_x), .m(in_m), .fin(in_flags),
    .res(ar_res), .fout(ar_f)
  );

  acc_alu_logic #(.DW(DW)) u_logic (
    .op(op), .a(in_a), .m(in_m), .fin(in_flags),
    .res(lg_res), .fout(lg_f)
  );

  assign nxt_res  = uses_adder(op) ? ar_res : lg_res;
  assign nxt_f    = uses_adder(op) ? ar_f : lg_f;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_flags  <= '0;
      op_q       <= OP_ADD;
    end else if (take) begin
      out_valid  <= 1'b1;
      out_result <= nxt_res;
      out_flags  <= nxt_f;
      op_q       <= op;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_result) && $stable(out_flags)));

  // R5
  logic_keeps_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == OP_AND) |=>
      (out_flags[FLAG_V] == $past(in_flags[FLAG_V])));

  // R6
  test_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == OP_TEST) |=>
      (out_flags[FLAG_N] == $past(in_m[DW-1])));

  // R3
  zero_matches_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (op_q == OP_ADD || op_q == OP_SUB || op_q == OP_XOR)) |->
      (out_flags[FLAG_Z] == (out_result == '0)));

endmodule

// File: tb/acc_alu_stage_tb.sv
module acc_alu_stage_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [4:0] in_op = '0;
  logic [7:0] in_a = '0, in_x = '0, in_m = '0;
  logic [3:0] in_flags = '0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_result;
  logic [3:0] out_flags;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [16:0] expq[$];
  int stall_pct = 25;

  always #2 clk = ~clk;

  acc_alu_stage u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_x(in_x), .in_m(in_m), .in_flags(in_flags),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_flags(out_flags)
  );

  function automatic string tag(int op);
    if (op <= 1) return "R3";
    if (op == 5 || op == 6) return "R4";
    if (op >= 2 && op <= 4) return "R5";
    if (op == 7) return "R6";
    if (op >= 8 && op <= 11) return "R7";
    if (op >= 12 && op <= 14) return "R8";
    if (op == 15) return "R9";
    if (op >= 16 && op <= 19) return "R10";
    return "R11";
  endfunction

  // behavioural reference: returns {result, N, V, Z, C}
  function automatic logic [11:0] model(int op, int a, int x, int m, logic [3:0] f);
    int n = f[3], v = f[2], z = f[1], c = f[0];
    int r = a, s, t, u;
    bit nz = 1;
    case (op)
      0, 1: begin
        u = (op == 1) ? 255 - m : m;
        s = a + u + c; r = s & 255; c = s >> 8;
        v = (((s ^ a) & (s ^ u) & 128) != 0);
      end
      2: r = a & m;
      3: r = a | m;
      4: r = a ^ m;
      5, 6: begin
        t = (op == 5) ? a : x;
        c = (t >= m); z = (t == m); n = (((t - m) & 128) != 0); nz = 0;
      end
      7: begin n = (m >> 7) & 1; v = (m >> 6) & 1; z = ((a & m) == 0); nz = 0; end
      8: begin c = (m >> 7) & 1; r = (m << 1) & 255; end
      9: begin c = m & 1; r = m >> 1; end
      10: begin r = ((m << 1) | c) & 255; c = (m >> 7) & 1; end
      11: begin r = (m >> 1) | (c << 7); c = m & 1; end
      12: begin r = a & m; c = (r >> 7) & 1; end
      13: begin r = ((a & m) >> 1) | (c << 7); c = (r >> 6) & 1; v = ((r >> 6) ^ (r >> 5)) & 1; end
      14: begin t = a & m; c = t & 1; r = t >> 1; end
      15: begin t = a & x; c = (t >= m); r = (t - m) & 255; end
      16: begin c = (m >> 7) & 1; r = a | ((m << 1) & 255); end
      17: begin u = ((m << 1) | c) & 255; c = (m >> 7) & 1; r = a & u; end
      18: begin c = m & 1; r = a ^ (m >> 1); end
      19: begin
        u = (m >> 1) | (c << 7);
        s = a + u + (m & 1); r = s & 255; c = s >> 8;
        v = (((s ^ a) & (s ^ u) & 128) != 0);
      end
      default: nz = 0;
    endcase
    if (nz) begin n = (r >> 7) & 1; z = (r == 0); end
    return {r[7:0], n[0], v[0], z[0], c[0]};
  endfunction

  // one clock: drive at the falling edge, compare, then predict
  task automatic tick(input bit v, input int op, input int a, input int x,
                      input int m, input logic [3:0] f, output bit took);
    logic [16:0] e;
    @(negedge clk);
    in_valid = v; in_op = op[4:0]; in_a = a[7:0]; in_x = x[7:0];
    in_m = m[7:0]; in_flags = f;
    out_ready = (($urandom % 100) >= stall_pct);
    #1;
    checks++;
    if (out_valid !== (expq.size() != 0)) begin
      errors++;
      $display("FAIL R2: out_valid actual %0b expected %0b", out_valid, expq.size() != 0);
    end
    if (out_valid && expq.size() != 0) begin
      e = expq[0];
      checks++;
      if ({out_result, out_flags} !== e[11:0]) begin
        errors++;
        $display("FAIL %s: op %0d result/flags actual %02h/%b expected %02h/%b",
                 tag(int'(e[16:12])), e[16:12], out_result, out_flags, e[11:4], e[3:0]);
      end
      if (out_ready) void'(expq.pop_front());
    end
    took = v && in_ready;
    if (took) expq.push_back({op[4:0], model(op, a, x, m, f)});
  endtask

  task automatic send(input int op, input int a, input int x, input int m,
                      input logic [3:0] f);
    bit took = 0;
    while (!took) tick(1, op, a, x, m, f, took);
  endtask

  task automatic drain();
    bit t;
    stall_pct = 0;
    repeat (4) tick(0, 0, 0, 0, 0, 4'h0, t);
    stall_pct = 25;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (out_valid !== 1'b0 || out_result !== 8'h00 || out_flags !== 4'h0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1: valid/result/flags actual %b/%02h/%b expected 0/00/0000",
               out_valid, out_result, out_flags);
    end
    rst_n = 1'b1;
    // R3 corners: signed overflow, wrap to zero, borrow
    send(0, 8'h7F, 0, 8'h01, 4'b0000);
    send(0, 8'hFF, 0, 8'h01, 4'b0000);
    send(0, 8'h80, 0, 8'h80, 4'b0001);
    send(1, 8'h00, 0, 8'h01, 4'b0001);
    send(1, 8'h80, 0, 8'h01, 4'b0001);
    // R4 equal, less, greater
    send(5, 8'h40, 0, 8'h40, 4'b0100);
    send(5, 8'h10, 0, 8'h20, 4'b0000);
    send(6, 0, 8'h90, 8'h10, 4'b0000);
    // R5 keeps C and V
    send(2, 8'hF0, 0, 8'h0F, 4'b0101);
    send(3, 8'h00, 0, 8'h80, 4'b0101);
    // R6
    send(7, 8'h01, 0, 8'hC0, 4'b0001);
    // R7 rotates through carry
    send(11, 0, 0, 8'h01, 4'b0001);
    send(10, 0, 0, 8'h80, 4'b0000);
    // R8
    send(13, 8'hFF, 0, 8'hC0, 4'b0001);
    send(13, 8'hFF, 0, 8'h40, 4'b0000);
    send(12, 8'h80, 0, 8'hFF, 4'b0000);
    send(14, 8'h03, 0, 8'h03, 4'b0000);
    // R9 borrow and exact
    send(15, 8'h0F, 8'hFF, 8'h10, 4'b0000);
    send(15, 8'h0F, 8'h0F, 8'h0F, 4'b0000);
    // R10
    send(19, 8'h7F, 0, 8'h03, 4'b0000);
    send(16, 8'h01, 0, 8'h80, 4'b0000);
    send(17, 8'h00, 0, 8'h55, 4'b0001);
    send(18, 8'h7F, 0, 8'hFF, 4'b0000);
    // R11 unassigned
    send(25, 8'h12, 0, 8'h34, 4'b1010);
    drain();
    // R2 under heavy back-pressure, then random mix
    stall_pct = 70;
    for (int i = 0; i < 300; i++)
      send($urandom % 32, $urandom % 256, $urandom % 256, $urandom % 256, 4'($urandom));
    stall_pct = 25;
    for (int i = 0; i < 1500; i++)
      send($urandom % 32, $urandom % 256, $urandom % 256, $urandom % 256, 4'($urandom));
    drain();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL R2: watchdog expired, actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule